// File: doc/BRIEF.md
# Timer With Shared Prescaler

This block is an 8-bit timer/counter whose programmable prescaler is shared with a watchdog. Its count source is either the instruction-cycle tick or edges on an external clock pin. The pin is brought into the clock domain by a two-flop synchroniser, and a selectable edge (rising or falling) produces the count event. The single prescaler is placed in front of only one consumer at a time. When it serves the timer, the timer advances once every 2 to 256 source events. When it serves the watchdog, the timer advances on every source event, and the watchdog oscillator ticks are divided by 1 to 128 before they leave the block as a watchdog tick.

Software controls the block through an 8-bit configuration register, a timer write port, an overflow-flag clear and a watchdog clear. The timer wraps from FFh to 00h and sets a sticky overflow flag. The flag stays set until it is cleared explicitly. The downstream watchdog counter and the interrupt controller lie outside the block.

Top module: `shared_prescale_timer`

## Requirements
- R1: After reset the timer value is 00h, the overflow flag is 0, the watchdog tick is 0 and every configuration bit is 1. So the timer counts falling external edges one-for-one, and the watchdog tick fires once per 128 oscillator ticks.
- R2: Configuration bit 5 selects the count source. With bit 5 at 0, each cycle in which cycle_tick is high is one source event.
- R3: With bit 5 at 1, the source events are external pin transitions. Bit 4 at 0 selects rising edges and bit 4 at 1 selects falling edges. A pin change reaches the timer on the third rising clock edge after it is applied (two synchroniser stages and one timer register).
- R4: With bit 3 at 0, the prescaler serves the timer. Rate code bits 2:0 give a division of 2^(code+1), so the timer advances once per 2, 4, 8 … 256 source events.
- R5: With bit 3 at 1, the timer advances on every source event. The watchdog tick pulses once per 2^code oscillator ticks (1 to 128), one clock after the oscillator tick that completes the count.
- R6: With bit 3 at 0, wdt_tick repeats wdt_osc_tick undivided, one clock later.
- R7: An increment from FFh gives 00h and sets the overflow flag. The flag stays set until flag_clr is asserted. If an overflow and flag_clr occur in the same cycle, the flag is set.
- R8: A timer write loads tmr_wdata and takes precedence over an increment in the same cycle. While bit 3 is 0, the write also restarts the prescaler count.
- R9: While bit 3 is 1, wdt_clr restarts the prescaler count and suppresses the watchdog tick of that cycle. While bit 3 is 0, wdt_clr has no effect on the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_tick | input | 1 | One-clock pulse per instruction cycle |
| ext_clk_pin | input | 1 | Asynchronous external count pin |
| wdt_osc_tick | input | 1 | One-clock pulse per watchdog oscillator period |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration: [5] source, [4] edge, [3] assignment, [2:0] rate |
| tmr_wr | input | 1 | Timer write strobe |
| tmr_wdata | input | 8 | Timer write data |
| flag_clr | input | 1 | Clears the overflow flag |
| wdt_clr | input | 1 | Watchdog clear |
| tmr_value | output | 8 | Current timer value |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_tick | output | 1 | Tick to the downstream watchdog counter |

## Verification
A wrong prescaler count is hidden until the next division boundary. At that point it shows as a timer increment or a watchdog tick arriving early or late, which can take up to 256 source events. The reference model therefore runs every rate long enough to cross several boundaries. It also places writes and clears in the middle of a count, so that a count that was not restarted becomes visible within one division period. A synchroniser fault shows within three clocks of a pin change as a shifted or missing increment. A flag fault shows at the first wrap, or at the first cycle after a clear.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

    localparam int CFG_W = 8;

    // Configuration layout (MSB first): spare[7:6], src_ext[5], fall_edge[4],
    // to_wdt[3], rate[2:0]
    typedef struct packed {
        logic [1:0] spare;
        logic       src_ext;
        logic       fall_edge;
        logic       to_wdt;
        logic [2:0] rate;
    } cfg_t;

    localparam cfg_t CFG_RESET = cfg_t'({CFG_W{1'b1}});

endpackage

// File: rtl/tsp_pin_sync.sv
module tsp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int DEPTH = STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] sh;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[DEPTH-2:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // The oldest stage holds the previous synchronised level.
    assign rise =  st_q.sh[STAGES-1] & ~st_q.sh[STAGES];
    assign fall = ~st_q.sh[STAGES-1] &  st_q.sh[STAGES];
endmodule

// File: rtl/tsp_prescaler.sv
module tsp_prescaler #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              clr,
    input  logic              to_wdt,
    input  logic [RATE_W-1:0] rate,
    output logic              tick_out
);
    localparam int PRE_W = 1 << RATE_W;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } state_t;

    state_t           st_d, st_q;
    logic [RATE_W:0]  shift_amt;
    logic [PRE_W:0]   one_hot;
    logic [PRE_W-1:0] mask;
    logic             hit;

    always_comb begin
        // The watchdog gets one octave less division than the timer.
        shift_amt = to_wdt ? {1'b0, rate} : ({1'b0, rate} + (RATE_W+1)'(1));
        one_hot   = (PRE_W+1)'(1) << shift_amt;
        mask      = PRE_W'(one_hot - (PRE_W+1)'(1));
        hit       = (st_q.cnt & mask) == mask;
        tick_out  = tick_in && !clr && hit;

        st_d = st_q;
        if (clr)          st_d.cnt = '0;
        else if (tick_in) st_d.cnt = st_q.cnt + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tsp_counter.sv
module tsp_counter #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             wr,
    input  logic [TMR_W-1:0] wdata,
    input  logic             flag_clr,
    output logic [TMR_W-1:0] value,
    output logic             flag
);
    localparam logic [TMR_W-1:0] TOP = {TMR_W{1'b1}};

    typedef struct packed {
        logic [TMR_W-1:0] cnt;
        logic             ovf;
    } state_t;

    state_t st_d, st_q;
    logic   wrap;

    always_comb begin
        wrap = inc && !wr && (st_q.cnt == TOP);
        st_d = st_q;
        if (wr)       st_d.cnt = wdata;
        else if (inc) st_d.cnt = st_q.cnt + TMR_W'(1);
        if (wrap)          st_d.ovf = 1'b1;
        else if (flag_clr) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.cnt;
    assign flag  = st_q.ovf;
endmodule

// File: rtl/shared_prescale_timer.sv
module shared_prescale_timer
    import tsp_pkg::*;
#(
    parameter int TMR_W       = 8,
    parameter int RATE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_tick,
    input  logic             ext_clk_pin,
    input  logic             wdt_osc_tick,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             tmr_wr,
    input  logic [TMR_W-1:0] tmr_wdata,
    input  logic             flag_clr,
    input  logic             wdt_clr,
    output logic [TMR_W-1:0] tmr_value,
    output logic             ovf_flag,
    output logic             wdt_tick
);
    typedef struct packed {
        cfg_t cfg;
        logic wdt;
    } state_t;

    state_t st_d, st_q;
    cfg_t   cfg_q;
    logic   pin_rise, pin_fall;
    logic   edge_ev, src_ev, pre_in, pre_clr, pre_out, tmr_inc;

    tsp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (ext_clk_pin),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    assign cfg_q = st_q.cfg;

    always_comb begin
        edge_ev = cfg_q.fall_edge ? pin_fall : pin_rise;
        src_ev  = cfg_q.src_ext ? edge_ev : cycle_tick;
        pre_in  = cfg_q.to_wdt ? wdt_osc_tick : src_ev;
        pre_clr = cfg_q.to_wdt ? wdt_clr : tmr_wr;
    end

    tsp_prescaler #(.RATE_W(RATE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_in (pre_in),
        .clr     (pre_clr),
        .to_wdt  (cfg_q.to_wdt),
        .rate    (cfg_q.rate[RATE_W-1:0]),
        .tick_out(pre_out)
    );

    always_comb begin
        tmr_inc = cfg_q.to_wdt ? src_ev : pre_out;
        st_d    = st_q;
        st_d.wdt = cfg_q.to_wdt ? pre_out : wdt_osc_tick;
        if (cfg_wr) st_d.cfg = cfg_t'(cfg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= CFG_RESET;
            st_q.wdt <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    tsp_counter #(.TMR_W(TMR_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (tmr_inc),
        .wr      (tmr_wr),
        .wdata   (tmr_wdata),
        .flag_clr(flag_clr),
        .value   (tmr_value),
        .flag    (ovf_flag)
    );

    assign wdt_tick = st_q.wdt;
endmodule

// File: rtl/tsp_checker.sv
module tsp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tmr_wr,
    input logic [7:0] tmr_wdata,
    input logic       flag_clr,
    input logic       wdt_osc_tick,
    input logic       to_wdt,
    input logic       tmr_inc,
    input logic [7:0] tmr_value,
    input logic       ovf_flag,
    input logic       wdt_tick
);
    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wr |=> tmr_value == $past(tmr_wdata));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_wr |=> (tmr_value == $past(tmr_value) ||
                     tmr_value == $past(tmr_value) + 8'd1));

    p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_wr && tmr_inc) |=> tmr_value == $past(tmr_value) + 8'd1);

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_wr && tmr_inc && tmr_value == 8'hFF) |=> ovf_flag);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !to_wdt |=> wdt_tick == $past(wdt_osc_tick));
endmodule

bind shared_prescale_timer tsp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tmr_wr      (tmr_wr),
    .tmr_wdata   (tmr_wdata),
    .flag_clr    (flag_clr),
    .wdt_osc_tick(wdt_osc_tick),
    .to_wdt      (cfg_q.to_wdt),
    .tmr_inc     (tmr_inc),
    .tmr_value   (tmr_value),
    .ovf_flag    (ovf_flag),
    .wdt_tick    (wdt_tick)
);

// File: tb/test_shared_prescale_timer.sv
module test_shared_prescale_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cycle_tick = 0, ext_clk_pin = 0, wdt_osc_tick = 0;
    logic       cfg_wr = 0, tmr_wr = 0, flag_clr = 0, wdt_clr = 0;
    logic [7:0] cfg_wdata = 0, tmr_wdata = 0;
    logic [7:0] tmr_value;
    logic       ovf_flag, wdt_tick;

    int    checks = 0, failures = 0;
    string cur_req = "R1";

    // reference model state
    int m_cfg, m_s1, m_s2, m_s3, m_pc, m_tmr, m_flag, m_wdt;

    always #5 clk = ~clk;

    shared_prescale_timer i_shared_prescale_timer (
        .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick),
        .ext_clk_pin(ext_clk_pin), .wdt_osc_tick(wdt_osc_tick),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .tmr_wr(tmr_wr),
        .tmr_wdata(tmr_wdata), .flag_clr(flag_clr), .wdt_clr(wdt_clr),
        .tmr_value(tmr_value), .ovf_flag(ovf_flag), .wdt_tick(wdt_tick)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 255; m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_pc = 0; m_tmr = 0; m_flag = 0; m_wdt = 0;
        end else begin
            int asg, rate, ev, src, pre_in, ratio, clr, pre_out, inc, ovf;
            asg  = (m_cfg >> 3) & 1;
            rate = m_cfg & 7;
            if ((m_cfg >> 4) & 1) ev = (!m_s2 && m_s3) ? 1 : 0;
            else                  ev = (m_s2 && !m_s3) ? 1 : 0;
            src    = ((m_cfg >> 5) & 1) ? ev : int'(cycle_tick);
            pre_in = asg ? int'(wdt_osc_tick) : src;
            ratio  = asg ? (1 << rate) : (2 << rate);
            clr    = asg ? int'(wdt_clr) : int'(tmr_wr);
            pre_out = (pre_in && !clr && ((m_pc + 1) % ratio == 0)) ? 1 : 0;
            if (clr) m_pc = 0;
            else if (pre_in) m_pc = (m_pc + 1) % 256;
            inc   = asg ? src : pre_out;
            m_wdt = asg ? pre_out : int'(wdt_osc_tick);
            ovf = 0;
            if (tmr_wr) m_tmr = int'(tmr_wdata);
            else if (inc) begin
                if (m_tmr == 255) ovf = 1;
                m_tmr = (m_tmr + 1) % 256;
            end
            if (ovf) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (cfg_wr) m_cfg = int'(cfg_wdata);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ext_clk_pin);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "tmr_value", int'(tmr_value), m_tmr);
            check(cur_req, "ovf_flag", int'(ovf_flag), m_flag);
            check(cur_req, "wdt_tick", int'(wdt_tick), m_wdt);
        end
    end

    task automatic step(input logic ct, input logic osc);
        cycle_tick = ct; wdt_osc_tick = osc;
        @(negedge clk);
        cycle_tick = 0; wdt_osc_tick = 0;
    endtask

    task automatic wcfg(input logic [7:0] v);
        cfg_wr = 1; cfg_wdata = v; @(negedge clk); cfg_wr = 0;
    endtask

    task automatic wtmr(input logic [7:0] v, input logic ct);
        tmr_wr = 1; tmr_wdata = v; cycle_tick = ct;
        @(negedge clk); tmr_wr = 0; cycle_tick = 0;
    endtask

    task automatic pin_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_pin = 1; repeat (4) step(0, 0);
            ext_clk_pin = 0; repeat (4) step(0, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n, pulses;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset values and all-ones configuration
        cur_req = "R1";
        check("R1", "reset tmr_value", int'(tmr_value), 0);
        check("R1", "reset ovf_flag", int'(ovf_flag), 0);
        check("R1", "reset wdt_tick", int'(wdt_tick), 0);
        pin_pulses(3);
        check("R1", "falling edges counted 1:1", int'(tmr_value), 3);
        pulses = 0;
        for (int i = 0; i < 128; i++) begin step(0, 1); pulses += int'(wdt_tick); end
        check("R1", "wdt ticks per 128 osc", pulses, 1);

        // R2: instruction-cycle source, watchdog assignment, rate 0
        cur_req = "R2";
        wcfg(8'b0000_1000);
        wtmr(8'h00, 0);
        n = 0;
        for (int i = 0; i < 60; i++) begin
            logic t; t = 1'($urandom_range(0, 1)); n += int'(t); step(t, 0);
        end
        check("R2", "cycle ticks counted", int'(tmr_value), n % 256);

        // R3: external rising then falling edges, latency
        cur_req = "R3";
        wcfg(8'b0010_1000);
        wtmr(8'h00, 0);
        pin_pulses(5);
        check("R3", "rising edges", int'(tmr_value), 5);
        ext_clk_pin = 1; step(0, 0); step(0, 0);
        check("R3", "no count after two clocks", int'(tmr_value), 5);
        step(0, 0);
        check("R3", "count on third clock", int'(tmr_value), 6);
        ext_clk_pin = 0; repeat (4) step(0, 0);
        wcfg(8'b0011_1000);
        wtmr(8'h00, 0);
        pin_pulses(4);
        check("R3", "falling edges", int'(tmr_value), 4);

        // R4: prescaler on timer, every rate
        cur_req = "R4";
        for (int r = 0; r < 8; r++) begin
            wcfg(8'(r));
            wtmr(8'h00, 0);
            repeat (4 << r) step(1, 0);
            check("R4", $sformatf("rate %0d after 2x ratio", r), int'(tmr_value), 2);
        end

        // R5: watchdog division
        cur_req = "R5";
        wcfg(8'b0000_1011);
        wdt_clr = 1; step(0, 0); wdt_clr = 0;
        pulses = 0;
        for (int i = 0; i < 32; i++) begin step(0, 1); pulses += int'(wdt_tick); end
        check("R5", "wdt ticks rate 3", pulses, 4);
        wtmr(8'h00, 0);
        repeat (7) step(1, 0);
        check("R5", "timer 1:1 under wdt assignment", int'(tmr_value), 7);

        // R6: undivided pass-through
        cur_req = "R6";
        wcfg(8'b0000_0101);
        step(0, 1);
        check("R6", "wdt_tick follows osc", int'(wdt_tick), 1);
        step(0, 0);
        check("R6", "wdt_tick low", int'(wdt_tick), 0);
        for (int i = 0; i < 40; i++) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        // R7: overflow flag
        cur_req = "R7";
        wcfg(8'b0000_1000);
        wtmr(8'hFE, 0);
        step(1, 0);
        check("R7", "FF no flag", int'(ovf_flag), 0);
        step(1, 0);
        check("R7", "wrap value", int'(tmr_value), 0);
        check("R7", "flag set on wrap", int'(ovf_flag), 1);
        repeat (3) step(1, 0);
        check("R7", "flag sticky", int'(ovf_flag), 1);
        flag_clr = 1; step(0, 0); flag_clr = 0;
        check("R7", "flag cleared", int'(ovf_flag), 0);
        wtmr(8'hFF, 0);
        flag_clr = 1; step(1, 0); flag_clr = 0;
        check("R7", "set wins over clear", int'(ovf_flag), 1);

        // R8: write precedence and prescaler restart
        cur_req = "R8";
        wtmr(8'h10, 1);
        check("R8", "write beats increment", int'(tmr_value), 16);
        wcfg(8'b0000_0010);
        wtmr(8'h00, 0);
        repeat (5) step(1, 0);
        wtmr(8'h40, 0);
        repeat (7) step(1, 0);
        check("R8", "restarted prescaler 7 of 8", int'(tmr_value), 'h40);
        step(1, 0);
        check("R8", "restarted prescaler 8 of 8", int'(tmr_value), 'h41);

        // R9: watchdog clear
        cur_req = "R9";
        wcfg(8'b0000_1010);
        wdt_clr = 1; step(0, 0); wdt_clr = 0;
        pulses = 0;
        repeat (3) begin step(0, 1); pulses += int'(wdt_tick); end
        wdt_clr = 1; step(0, 0); wdt_clr = 0;
        repeat (3) begin step(0, 1); pulses += int'(wdt_tick); end
        check("R9", "clear restarts wdt count", pulses, 0);
        step(0, 1);
        check("R9", "tick after full count", int'(wdt_tick), 1);
        wcfg(8'b0000_0001);
        wtmr(8'h00, 0);
        repeat (2) step(1, 0);
        wdt_clr = 1; step(0, 0); wdt_clr = 0;
        repeat (2) step(1, 0);
        check("R9", "wdt_clr leaves timer prescaler", int'(tmr_value), 1);

        // mixed random traffic against the model
        cur_req = "R4";
        for (int i = 0; i < 3000; i++) begin
            if (i % 500 == 0) wcfg(8'($urandom_range(0, 63)));
            ext_clk_pin = 1'($urandom_range(0, 1));
            wdt_clr = ($urandom_range(0, 40) == 0);
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            wdt_clr = 0;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule